// File: doc/BRIEF.md
# Edge-Pulse Isolation Channel Codec

This block carries a single logic level over a link that can only convey short pulses, the way a transformer-coupled isolator does. An encoder on the sending side watches the input level. On every rising transition it raises a one-cycle pulse on a "set" line, and on every falling transition it raises a one-cycle pulse on a "clear" line. When the input stays still, the encoder repeats a pulse that matches the present level at a fixed interval. These refresh pulses let the receiving side recover the correct static level even if an edge pulse was lost.

A decoder on the receiving side is a set/clear bistable, written as a three-state machine. `DEC_DEAD` means that no link is present. `DEC_LOW` and `DEC_HIGH` hold the received level. A set pulse moves the machine to `DEC_HIGH` from any state. A clear pulse moves it to `DEC_LOW`. If set and clear arrive in the same cycle, the set pulse wins. A watchdog counts the cycles since the last pulse. When the count reaches the timeout, the machine drops to `DEC_DEAD`. In that state the output takes a parameterised default level and the valid flag is low.

The encoder machine has three states. `ENC_WAIT` sends no pulse. `ENC_EDGE` sends a pulse because the input changed. `ENC_RFSH` sends a pulse because the refresh interval ran out. An edge takes precedence over a refresh that is due in the same cycle, and every pulse sent restarts the refresh interval. The encoder and decoder halves have separate ports, so the system can route the pulse lines through whatever stands between the two sides.

Top module: `edge_iso_codec`

## Requirements
- R1: A rising input level sampled at a clock edge gives `tx_set`=1 and `tx_clr`=0 for exactly the following cycle. A falling level gives `tx_clr`=1 and `tx_set`=0 for that cycle.
- R2: `tx_set` and `tx_clr` are never high together, and each pulse lasts one cycle.
- R3: While the input stays constant, the encoder sends a pulse that matches the level (set for 1, clear for 0) every `REFRESH_CYC` cycles after the previous pulse. When the encoder output is looped back to the decoder, `rx_valid` therefore stays high indefinitely.
- R4: An input edge restarts the refresh interval. The first refresh after an edge pulse comes exactly `REFRESH_CYC` cycles after it.
- R5: A `rx_set` pulse makes `rx_level`=1 and a `rx_clr` pulse makes `rx_level`=0 from the next cycle on. Both set `rx_valid`=1, and the level holds between pulses.
- R6: When `rx_set` and `rx_clr` are both high in the same cycle, the decoder takes the set: `rx_level`=1 in the next cycle.
- R7: After `TIMEOUT_CYC` consecutive cycles with no received pulse, `rx_valid` goes to 0 and `rx_level` equals `DEFAULT_LVL`. A pulse that arrives on the cycle the timeout would expire keeps the link valid and takes effect.
- R8: During and after reset, `tx_set`=`tx_clr`=0, `rx_valid`=0 and `rx_level`=`DEFAULT_LVL`. The first received pulse makes the link valid.
- R9: Any received pulse restarts the watchdog, so the timeout is counted from the most recent pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both halves |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_level | input | 1 | Logic level to be sent |
| tx_set | output | 1 | Encoder pulse: level is (or became) high |
| tx_clr | output | 1 | Encoder pulse: level is (or became) low |
| rx_set | input | 1 | Received set pulse |
| rx_clr | input | 1 | Received clear pulse |
| rx_level | output | 1 | Recovered level, or `DEFAULT_LVL` when the link is dead |
| rx_valid | output | 1 | High while pulses arrive within the timeout |

## Verification
The coincidence that matters most is the decoder watchdog expiring in the same cycle that a pulse arrives. The bench breaks the loopback and injects one clear pulse. It then waits exactly `TIMEOUT_CYC` cycles and injects a set pulse on the edge where expiry would happen. The pulse must win: `rx_valid` stays high and `rx_level` becomes 1. A cycle-level reference model checks the encoder's edge-versus-refresh precedence and the simultaneous set/clear case on every clock.

// File: rtl/iso_codec_pkg.sv
package iso_codec_pkg;

    typedef enum logic [1:0] {
        ENC_WAIT = 2'd0,
        ENC_EDGE = 2'd1,
        ENC_RFSH = 2'd2
    } enc_state_e;

    typedef enum logic [1:0] {
        DEC_DEAD = 2'd0,
        DEC_LOW  = 2'd1,
        DEC_HIGH = 2'd2
    } dec_state_e;

endpackage

// File: rtl/iso_interval_timer.sv
// Saturating cycle counter; expired is high once LIMIT-1 cycles have been
// counted since the last clear.
module iso_interval_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LAST);
endmodule

// File: rtl/iso_edge_encoder.sv
module iso_edge_encoder
    import iso_codec_pkg::*;
#(
    parameter int REFRESH_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic pulse_set,
    output logic pulse_clr
);
    enc_state_e state_q, state_d;
    logic       lvl_q;
    logic       rfsh_due;

    iso_interval_timer #(.LIMIT(REFRESH_CYC)) u_rfsh_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_d != ENC_WAIT),
        .run     (1'b1),
        .expired (rfsh_due)
    );

    // next state: an edge outranks a refresh falling due in the same cycle
    always_comb begin
        if (level_in != lvl_q) begin
            state_d = ENC_EDGE;
        end else if (rfsh_due) begin
            state_d = ENC_RFSH;
        end else begin
            state_d = ENC_WAIT;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENC_WAIT;
            lvl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            lvl_q   <= level_in;
        end
    end

    // outputs
    always_comb begin
        pulse_set = 1'b0;
        pulse_clr = 1'b0;
        unique case (state_q)
            ENC_WAIT: begin
                pulse_set = 1'b0;
                pulse_clr = 1'b0;
            end
            ENC_EDGE, ENC_RFSH: begin
                pulse_set = lvl_q;
                pulse_clr = ~lvl_q;
            end
            default: begin
                pulse_set = 1'b0;
                pulse_clr = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/iso_pulse_decoder.sv
module iso_pulse_decoder
    import iso_codec_pkg::*;
#(
    parameter int   TIMEOUT_CYC = 500,
    parameter logic DEFAULT_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_set,
    input  logic pulse_clr,
    output logic level_out,
    output logic link_ok
);
    dec_state_e state_q, state_d;
    logic       starved;

    iso_interval_timer #(.LIMIT(TIMEOUT_CYC)) u_wd_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pulse_set | pulse_clr),
        .run     (state_q != DEC_DEAD),
        .expired (starved)
    );

    // next state: set beats clear, any pulse beats the watchdog
    always_comb begin
        state_d = state_q;
        if (pulse_set) begin
            state_d = DEC_HIGH;
        end else if (pulse_clr) begin
            state_d = DEC_LOW;
        end else begin
            unique case (state_q)
                DEC_DEAD:          state_d = DEC_DEAD;
                DEC_LOW, DEC_HIGH: state_d = starved ? DEC_DEAD : state_q;
                default:           state_d = DEC_DEAD;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DEC_DEAD;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        level_out = DEFAULT_LVL;
        link_ok   = 1'b0;
        unique case (state_q)
            DEC_DEAD: begin
                level_out = DEFAULT_LVL;
                link_ok   = 1'b0;
            end
            DEC_LOW: begin
                level_out = 1'b0;
                link_ok   = 1'b1;
            end
            DEC_HIGH: begin
                level_out = 1'b1;
                link_ok   = 1'b1;
            end
            default: begin
                level_out = DEFAULT_LVL;
                link_ok   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/edge_iso_codec.sv
module edge_iso_codec #(
    parameter int   REFRESH_CYC = 100,
    parameter int   TIMEOUT_CYC = 500,
    parameter logic DEFAULT_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_level,
    output logic tx_set,
    output logic tx_clr,
    input  logic rx_set,
    input  logic rx_clr,
    output logic rx_level,
    output logic rx_valid
);
    iso_edge_encoder #(.REFRESH_CYC(REFRESH_CYC)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_in  (tx_level),
        .pulse_set (tx_set),
        .pulse_clr (tx_clr)
    );

    iso_pulse_decoder #(
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .DEFAULT_LVL (DEFAULT_LVL)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_set (rx_set),
        .pulse_clr (rx_clr),
        .level_out (rx_level),
        .link_ok   (rx_valid)
    );
endmodule

// File: rtl/edge_iso_codec_chk.sv
module edge_iso_codec_chk #(
    parameter int   TIMEOUT_CYC = 500,
    parameter logic DEFAULT_LVL = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic tx_level,
    input logic tx_set,
    input logic tx_clr,
    input logic rx_set,
    input logic rx_clr,
    input logic rx_level,
    input logic rx_valid
);
    localparam int QW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [QW-1:0] QMAX = QW'(TIMEOUT_CYC);

    // cycles since the last received pulse, saturating
    logic [QW-1:0] quiet_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_q <= QMAX;
        end else if (rx_set || rx_clr) begin
            quiet_q <= '0;
        end else if (quiet_q != QMAX) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    // R2
    enc_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_set && tx_clr));

    // R1
    enc_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (tx_level != $past(tx_level)))
        |=> ((tx_set == $past(tx_level)) && (tx_clr == !$past(tx_level))));

    // R5
    dec_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_set |=> (rx_level && rx_valid));

    // R5
    dec_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clr && !rx_set) |=> (!rx_level && rx_valid));

    // R7
    dec_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> (rx_level == DEFAULT_LVL));

    // R9
    dec_watchdog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid == (quiet_q < QMAX));
endmodule

bind edge_iso_codec edge_iso_codec_chk #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .DEFAULT_LVL (DEFAULT_LVL)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_level (tx_level),
    .tx_set   (tx_set),
    .tx_clr   (tx_clr),
    .rx_set   (rx_set),
    .rx_clr   (rx_clr),
    .rx_level (rx_level),
    .rx_valid (rx_valid)
);

// File: tb/sim_edge_iso_codec.sv
module sim_edge_iso_codec;
    localparam int   RFR = 20;
    localparam int   TMO = 50;
    localparam logic DEF = 1'b1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic cut = 1'b0;
    logic inj_s = 1'b0;
    logic inj_c = 1'b0;
    logic tx_set, tx_clr, rx_set, rx_clr, rx_level, rx_valid;

    always #4 clk = ~clk;

    assign rx_set = cut ? inj_s : tx_set;
    assign rx_clr = cut ? inj_c : tx_clr;

    edge_iso_codec #(.REFRESH_CYC(RFR), .TIMEOUT_CYC(TMO), .DEFAULT_LVL(DEF)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_level(din), .tx_set(tx_set), .tx_clr(tx_clr),
        .rx_set(rx_set), .rx_clr(rx_clr), .rx_level(rx_level), .rx_valid(rx_valid)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    bit m_lvl = 0, m_set = 0, m_clr = 0, m_ok = 0, m_val = 0;
    bit ls, lc;
    int m_since = 0, m_quiet = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lvl = 0; m_set = 0; m_clr = 0; m_ok = 0; m_val = 0;
            m_since = 0; m_quiet = 0;
        end else begin
            ls = cut ? inj_s : m_set;
            lc = cut ? inj_c : m_clr;
            if (ls) begin
                m_ok = 1; m_val = 1; m_quiet = 0;
            end else if (lc) begin
                m_ok = 1; m_val = 0; m_quiet = 0;
            end else if (m_ok) begin
                m_quiet++;
                if (m_quiet == TMO) m_ok = 0;
            end
            m_set = 0; m_clr = 0;
            if (din != m_lvl) begin
                m_lvl = din; m_set = din; m_clr = !din; m_since = 0;
            end else begin
                m_since++;
                if (m_since == RFR) begin
                    m_set = m_lvl; m_clr = !m_lvl; m_since = 0;
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        chk("R1 tx_set model", int'(tx_set), int'(m_set));
        chk("R1 tx_clr model", int'(tx_clr), int'(m_clr));
        chk("R5 rx_level model", int'(rx_level), int'(m_ok ? m_val : DEF));
        chk("R7 rx_valid model", int'(rx_valid), int'(m_ok));
    end

    // pulse spacing monitor
    int cyc = 0, last_pulse = 0, last_gap = 0, both_cnt = 0;
    bit last_kind_set = 0;
    always @(posedge clk) cyc++;
    always @(negedge clk) begin
        if (tx_set && tx_clr) both_cnt++;
        if (tx_set || tx_clr) begin
            last_gap = cyc - last_pulse;
            last_pulse = cyc;
            last_kind_set = tx_set;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 reset tx_set", int'(tx_set), 0);
        chk("R8 reset tx_clr", int'(tx_clr), 0);
        chk("R8 reset rx_valid", int'(rx_valid), 0);
        chk("R8 reset rx_level", int'(rx_level), int'(DEF));
        rst_n = 1'b1;

        repeat (45) @(negedge clk);
        chk("R3 refresh spacing", last_gap, RFR);
        chk("R3 refresh kind clear", int'(last_kind_set), 0);
        chk("R8 first pulse validates", int'(rx_valid), 1);
        chk("R5 level low", int'(rx_level), 0);

        din = 1'b1;
        @(negedge clk);
        chk("R1 rising set", int'(tx_set), 1);
        chk("R1 rising no clr", int'(tx_clr), 0);
        @(negedge clk);
        chk("R2 set one cycle", int'(tx_set), 0);
        chk("R5 level high", int'(rx_level), 1);

        repeat (7) @(negedge clk);
        din = 1'b0;
        @(negedge clk);
        chk("R1 falling clr", int'(tx_clr), 1);
        chk("R1 falling no set", int'(tx_set), 0);
        repeat (25) @(negedge clk);
        chk("R4 refresh after edge", last_gap, RFR);
        chk("R5 level follows", int'(rx_level), 0);

        repeat (3 * TMO) @(negedge clk);
        chk("R3 loop stays valid", int'(rx_valid), 1);
        chk("R2 never both", both_cnt, 0);

        // dead sender: break loop, one clear pulse, then silence
        cut = 1'b1; inj_c = 1'b1;
        @(negedge clk);
        inj_c = 1'b0;
        repeat (TMO - 1) @(negedge clk);
        chk("R7 alive before timeout", int'(rx_valid), 1);
        @(negedge clk);
        chk("R7 dead at timeout", int'(rx_valid), 0);
        chk("R7 default level", int'(rx_level), int'(DEF));

        // set and clear together
        inj_s = 1'b1; inj_c = 1'b1;
        @(negedge clk);
        inj_s = 1'b0; inj_c = 1'b0;
        chk("R6 set wins", int'(rx_level), 1);
        chk("R8 revalidate", int'(rx_valid), 1);
        inj_c = 1'b1;
        @(negedge clk);
        inj_c = 1'b0;
        chk("R5 clear pulse", int'(rx_level), 0);

        // watchdog restart
        repeat (39) @(negedge clk);
        inj_s = 1'b1;
        @(negedge clk);
        inj_s = 1'b0;
        repeat (TMO - 1) @(negedge clk);
        chk("R9 restarted watchdog", int'(rx_valid), 1);
        @(negedge clk);
        chk("R9 timeout from last pulse", int'(rx_valid), 0);

        // pulse on the expiry edge
        inj_c = 1'b1;
        @(negedge clk);
        inj_c = 1'b0;
        chk("R8 pulse after dead", int'(rx_valid), 1);
        repeat (TMO - 1) @(negedge clk);
        inj_s = 1'b1;
        @(negedge clk);
        inj_s = 1'b0;
        chk("R7 pulse at expiry valid", int'(rx_valid), 1);
        chk("R7 pulse at expiry level", int'(rx_level), 1);

        cut = 1'b0;
        repeat (2 * RFR) @(negedge clk);
        chk("R3 reconnect valid", int'(rx_valid), 1);
        chk("R3 reconnect level", int'(rx_level), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule